// File: doc/BRIEF.md
# Processor Hotplug Slot Controller

This block keeps the hot-add and hot-remove bookkeeping for a fixed set of processor slots and exposes it to firmware through a small register window of three 32-bit words. Firmware first writes a slot selector, then reads or clears that slot's flags, issues commands, and moves data through a command-data word. One command scans the slots, starting at the selector and wrapping around, for the next slot with an event and moves the selector there. The other two commands store the firmware's status-reporting event code and result code for the selected slot.

The platform side reports a processor being plugged in, asked to leave, and gone, each with a slot index. The block drives a level interrupt while any event is pending. It emits a one-cycle eject request, with the slot index, when firmware asks to remove a slot that is present and is not the boot slot. It also pulses a notification that carries the slot, the stored event code and the new status code whenever firmware writes a status code.

The scan checks one slot per clock. While it runs the bus is held off through `busReady`.

Top module: `hotslot_regs`

## Requirements
- R1: After reset every slot is absent with no pending events, the selector and the command are 0, `evtIrq` is low and `busReady` is high.
- R2: A read of word 1 returns, for the selected slot, bit0 = present, bit1 = insert pending and bit2 = remove pending. All other bits are 0, and that includes the command byte (bits 15:8), which cannot be read back. Reads of word 0 and word 3 return 0.
- R3: While the selector is at least SLOTS, every read returns 0 and writes to words 1, 2 and 3 change nothing. A write to the selector (word 0) is always taken.
- R4: A write to word 1 with byte lane 0 enabled acts on its data bits by priority. Bit1 clears insert pending. Otherwise bit2 clears remove pending. Otherwise bit3 requests an eject.
- R5: An eject request produces `ejectValid` for one cycle, with `ejectSlot` equal to the selector, on the clock edge after the write. This happens only if the slot is present and is not slot 0. Otherwise no pulse is produced.
- R6: A write to word 1 with byte lane 1 enabled loads bits 15:8 as the command: 0 = scan, 1 = store event code, 2 = store status code. A value of 3 or more leaves the command unchanged.
- R7: Command 0 checks slots one per cycle, starting at the selector and wrapping from SLOTS-1 to 0. The first slot with insert or remove pending becomes the selector. If no slot has an event, the selector is unchanged after SLOTS cycles. A slot found k steps away holds `busReady` low for k+1 cycles.
- R8: A read of word 2 returns the whole selector when the command is 0, and 0 for any other command.
- R9: A write of word 2 under command 1 stores the event code for the selected slot. Under command 2 it pulses `ostNotify` on the next edge, with `ostSlot`, the stored `ostEvent` and `ostStatus` equal to the written data.
- R10: `plugValid` marks a slot present and, when `plugHot` is set, sets insert pending. `unplugReqValid` sets remove pending. `unplugDoneValid` clears present. An event being set beats a clear from firmware in the same cycle.
- R11: `evtIrq` is high exactly while at least one slot has insert or remove pending, one edge after the state changes.
- R12: Bus lanes are little-endian by byte enable. A selector write replaces only the enabled bytes. A word 2 write fills disabled lanes with zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Access request |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Word index: 0 selector, 1 flags/command, 2 command data |
| busBe | input | 4 | Byte enables, lane 0 = bits 7:0 |
| busWdata | input | 32 | Write data |
| busReady | output | 1 | Access accepted this cycle; low during a scan |
| busRdata | output | 32 | Read data, valid while busReq and busReady |
| plugValid | input | 1 | A processor was plugged into plugSlot |
| plugHot | input | 1 | The plug is a hot-add (raises insert pending) |
| plugSlot | input | IDXW | Slot of the plug |
| unplugReqValid | input | 1 | Removal of unplugReqSlot is requested |
| unplugReqSlot | input | IDXW | Slot asked to leave |
| unplugDoneValid | input | 1 | The processor in unplugDoneSlot is gone |
| unplugDoneSlot | input | IDXW | Slot that was vacated |
| evtIrq | output | 1 | Level: any insert or remove pending |
| ejectValid | output | 1 | One-cycle eject request |
| ejectSlot | output | IDXW | Slot to eject |
| ostNotify | output | 1 | One-cycle status notification |
| ostSlot | output | IDXW | Slot of the notification |
| ostEvent | output | 32 | Stored event code of that slot |
| ostStatus | output | 32 | Status code just written |

## Verification
The assertions assume that each platform input names a valid slot, and that a plug and an unplug completion never name the same slot in one cycle. They also assume bus requests are held until `busReady` is seen. The stimulus drives platform pulses only from tasks that run between bus accesses, never two at once, and with slot indices drawn below SLOTS. Each bus task waits out any scan before it issues the next access. Selector values are mostly in range, with occasional large ones to exercise the ignored-access rules.

// File: rtl/hotslot_pkg.sv
package hotslot_pkg;

  typedef enum logic [1:0] {
    CMD_SCAN  = 2'd0,
    CMD_OSTEV = 2'd1,
    CMD_OSTST = 2'd2
  } cmd_e;

  localparam logic [1:0] WORD_SEL  = 2'd0;
  localparam logic [1:0] WORD_CTL  = 2'd1;
  localparam logic [1:0] WORD_DATA = 2'd2;

  localparam int FLAG_CLR_INS = 1;
  localparam int FLAG_CLR_REM = 2;
  localparam int FLAG_EJECT   = 3;

  typedef struct packed {
    logic clrIns;
    logic clrRem;
    logic eject;
    logic ostEvWr;
    logic ostStWr;
  } strobe_t;

endpackage

// File: rtl/hotslot_dp.sv
module hotslot_dp
  import hotslot_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int DW    = 32,
  localparam int IDXW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [IDXW-1:0] slotIdx,
  input  logic [DW-1:0]   wdata,
  input  logic            plugValid,
  input  logic            plugHot,
  input  logic [IDXW-1:0] plugSlot,
  input  logic            unplugReqValid,
  input  logic [IDXW-1:0] unplugReqSlot,
  input  logic            unplugDoneValid,
  input  logic [IDXW-1:0] unplugDoneSlot,
  output logic [SLOTS-1:0] presentVec,
  output logic [SLOTS-1:0] insVec,
  output logic [SLOTS-1:0] remVec,
  output logic            evtIrq,
  output logic            ejectValid,
  output logic [IDXW-1:0] ejectSlot,
  output logic            ostNotify,
  output logic [IDXW-1:0] ostSlot,
  output logic [DW-1:0]   ostEvent,
  output logic [DW-1:0]   ostStatus
);

  logic [SLOTS*DW-1:0] evFlat;

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    logic presReg, insReg, remReg;
    logic [DW-1:0] evReg;
    logic hitSel;

    assign hitSel = (slotIdx == IDXW'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        presReg <= 1'b0;
        insReg  <= 1'b0;
        remReg  <= 1'b0;
        evReg   <= '0;
      end else begin
        if (plugValid && plugSlot == IDXW'(g))
          presReg <= 1'b1;
        else if (unplugDoneValid && unplugDoneSlot == IDXW'(g))
          presReg <= 1'b0;

        if (plugValid && plugHot && plugSlot == IDXW'(g))
          insReg <= 1'b1;
        else if (strb.clrIns && hitSel)
          insReg <= 1'b0;

        if (unplugReqValid && unplugReqSlot == IDXW'(g))
          remReg <= 1'b1;
        else if (strb.clrRem && hitSel)
          remReg <= 1'b0;

        if (strb.ostEvWr && hitSel)
          evReg <= wdata;
      end
    end

    assign presentVec[g]       = presReg;
    assign insVec[g]           = insReg;
    assign remVec[g]           = remReg;
    assign evFlat[g*DW +: DW]  = evReg;
  end

  assign evtIrq = |(insVec | remVec);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ejectValid <= 1'b0;
      ejectSlot  <= '0;
      ostNotify  <= 1'b0;
      ostSlot    <= '0;
      ostEvent   <= '0;
      ostStatus  <= '0;
    end else begin
      ejectValid <= strb.eject && presentVec[slotIdx] && (slotIdx != '0);
      ejectSlot  <= slotIdx;
      ostNotify  <= strb.ostStWr;
      if (strb.ostStWr) begin
        ostSlot   <= slotIdx;
        ostEvent  <= evFlat[slotIdx*DW +: DW];
        ostStatus <= wdata;
      end
    end
  end

  // Checker state: presence as seen on the previous cycle
  logic [SLOTS-1:0] presQ;
  always_ff @(posedge clk) begin
    if (!rstN) presQ <= '0;
    else       presQ <= presentVec;
  end

  a_r5_eject_guard: assert property (@(posedge clk) disable iff (!rstN)
    ejectValid |-> (ejectSlot != '0) && presQ[ejectSlot])
    else $error("eject issued for boot or absent slot");

  a_r10_plug_sets_insert: assert property (@(posedge clk) disable iff (!rstN)
    plugValid && plugHot |=> insVec[$past(plugSlot)] && presentVec[$past(plugSlot)])
    else $error("hot plug did not mark slot");

  a_r11_irq_follows_event: assert property (@(posedge clk) disable iff (!rstN)
    unplugReqValid |=> evtIrq)
    else $error("interrupt missing after unplug request");

  a_r9_notify_once: assert property (@(posedge clk) disable iff (!rstN)
    ostNotify |-> $past(strb.ostStWr))
    else $error("notify without status write");

endmodule

// File: rtl/hotslot_ctrl.sv
module hotslot_ctrl
  import hotslot_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int DW    = 32,
  localparam int IDXW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int NB   = DW / 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busReq,
  input  logic            busWr,
  input  logic [1:0]      busAddr,
  input  logic [NB-1:0]   busBe,
  input  logic [DW-1:0]   busWdata,
  output logic            busReady,
  output logic [DW-1:0]   busRdata,
  input  logic [SLOTS-1:0] presentVec,
  input  logic [SLOTS-1:0] insVec,
  input  logic [SLOTS-1:0] remVec,
  output strobe_t         strb,
  output logic [IDXW-1:0] slotIdx,
  output logic [DW-1:0]   wdataOut
);

  logic [DW-1:0]   selReg;
  cmd_e            cmdReg;
  logic            busy;
  logic [IDXW-1:0] iter;
  logic [IDXW:0]   lapCnt;

  logic [SLOTS-1:0] pendVec;
  logic selValid, wrAcc, ctlWr, cmdWr, dataWr;
  logic [7:0] flagByte, cmdByte;
  logic [DW-1:0] laneData;

  assign pendVec  = insVec | remVec;
  assign selValid = selReg < DW'(SLOTS);
  assign slotIdx  = selReg[IDXW-1:0];
  assign busReady = !busy;

  assign wrAcc  = busReq && busReady && busWr;
  assign ctlWr  = wrAcc && selValid && (busAddr == WORD_CTL);
  assign dataWr = wrAcc && selValid && (busAddr == WORD_DATA) && (|busBe);
  assign cmdWr  = ctlWr && busBe[1];
  assign flagByte = busBe[0] ? busWdata[7:0] : 8'h00;
  assign cmdByte  = busWdata[15:8];

  for (genvar b = 0; b < NB; b++) begin : gLane
    assign laneData[b*8 +: 8] = busBe[b] ? busWdata[b*8 +: 8] : 8'h00;
  end
  assign wdataOut = laneData;

  always_comb begin
    strb = '0;
    if (ctlWr) begin
      if (flagByte[FLAG_CLR_INS])      strb.clrIns = 1'b1;
      else if (flagByte[FLAG_CLR_REM]) strb.clrRem = 1'b1;
      else if (flagByte[FLAG_EJECT])   strb.eject  = 1'b1;
    end
    strb.ostEvWr = dataWr && (cmdReg == CMD_OSTEV);
    strb.ostStWr = dataWr && (cmdReg == CMD_OSTST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg <= '0;
      cmdReg <= CMD_SCAN;
      busy   <= 1'b0;
      iter   <= '0;
      lapCnt <= '0;
    end else if (busy) begin
      if (pendVec[iter]) begin
        selReg <= DW'(iter);
        busy   <= 1'b0;
      end else if (lapCnt == (IDXW+1)'(SLOTS - 1)) begin
        busy <= 1'b0;
      end else begin
        iter   <= (iter == IDXW'(SLOTS - 1)) ? '0 : iter + 1'b1;
        lapCnt <= lapCnt + 1'b1;
      end
    end else begin
      if (wrAcc && busAddr == WORD_SEL) begin
        for (int b = 0; b < NB; b++)
          if (busBe[b]) selReg[b*8 +: 8] <= busWdata[b*8 +: 8];
      end
      if (cmdWr) begin
        case (cmdByte)
          8'd0: begin
            cmdReg <= CMD_SCAN;
            busy   <= 1'b1;
            iter   <= slotIdx;
            lapCnt <= '0;
          end
          8'd1:    cmdReg <= CMD_OSTEV;
          8'd2:    cmdReg <= CMD_OSTST;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (selValid) begin
      case (busAddr)
        WORD_CTL:  busRdata[2:0] = {remVec[slotIdx], insVec[slotIdx], presentVec[slotIdx]};
        WORD_DATA: busRdata = (cmdReg == CMD_SCAN) ? selReg : '0;
        default:   busRdata = '0;
      endcase
    end
  end

  // Checker state
  logic [SLOTS-1:0] pendQ;
  logic [IDXW+1:0]  busyRun;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ   <= '0;
      busyRun <= '0;
    end else begin
      pendQ   <= pendVec;
      busyRun <= busy ? busyRun + 1'b1 : '0;
    end
  end

  a_r7_scan_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= (IDXW+2)'(SLOTS))
    else $error("scan exceeded slot count");

  a_r7_hit_has_event: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) && (selReg != $past(selReg)) |-> pendQ[slotIdx])
    else $error("scan stopped on slot without event");

  a_r6_bad_cmd_kept: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && (cmdByte > 8'd2) |=> $stable(cmdReg))
    else $error("invalid command altered register");

  a_r3_no_strobe_invalid: assert property (@(posedge clk) disable iff (!rstN)
    !selValid |-> (strb == '0))
    else $error("strobe issued with invalid selector");

endmodule

// File: rtl/hotslot_regs.sv
module hotslot_regs
  import hotslot_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int IDXW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busReq,
  input  logic            busWr,
  input  logic [1:0]      busAddr,
  input  logic [3:0]      busBe,
  input  logic [31:0]     busWdata,
  output logic            busReady,
  output logic [31:0]     busRdata,
  input  logic            plugValid,
  input  logic            plugHot,
  input  logic [IDXW-1:0] plugSlot,
  input  logic            unplugReqValid,
  input  logic [IDXW-1:0] unplugReqSlot,
  input  logic            unplugDoneValid,
  input  logic [IDXW-1:0] unplugDoneSlot,
  output logic            evtIrq,
  output logic            ejectValid,
  output logic [IDXW-1:0] ejectSlot,
  output logic            ostNotify,
  output logic [IDXW-1:0] ostSlot,
  output logic [31:0]     ostEvent,
  output logic [31:0]     ostStatus
);

  strobe_t         strb;
  logic [IDXW-1:0] slotIdx;
  logic [31:0]     wdataInt;
  logic [SLOTS-1:0] presentVec, insVec, remVec;

  hotslot_ctrl #(.SLOTS(SLOTS), .DW(32)) uCtrl (
    .clk(clk), .rstN(rstN),
    .busReq(busReq), .busWr(busWr), .busAddr(busAddr), .busBe(busBe),
    .busWdata(busWdata), .busReady(busReady), .busRdata(busRdata),
    .presentVec(presentVec), .insVec(insVec), .remVec(remVec),
    .strb(strb), .slotIdx(slotIdx), .wdataOut(wdataInt)
  );

  hotslot_dp #(.SLOTS(SLOTS), .DW(32)) uDp (
    .clk(clk), .rstN(rstN),
    .strb(strb), .slotIdx(slotIdx), .wdata(wdataInt),
    .plugValid(plugValid), .plugHot(plugHot), .plugSlot(plugSlot),
    .unplugReqValid(unplugReqValid), .unplugReqSlot(unplugReqSlot),
    .unplugDoneValid(unplugDoneValid), .unplugDoneSlot(unplugDoneSlot),
    .presentVec(presentVec), .insVec(insVec), .remVec(remVec),
    .evtIrq(evtIrq), .ejectValid(ejectValid), .ejectSlot(ejectSlot),
    .ostNotify(ostNotify), .ostSlot(ostSlot), .ostEvent(ostEvent),
    .ostStatus(ostStatus)
  );

endmodule

// File: tb/sim_hotslot_regs.sv
module sim_hotslot_regs;
  localparam int SLOTS = 8;
  localparam int IDXW  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReq = 1'b0, busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [3:0] busBe = '0;
  logic [31:0] busWdata = '0;
  logic busReady;
  logic [31:0] busRdata;
  logic plugValid = 1'b0, plugHot = 1'b0;
  logic [IDXW-1:0] plugSlot = '0;
  logic unplugReqValid = 1'b0;
  logic [IDXW-1:0] unplugReqSlot = '0;
  logic unplugDoneValid = 1'b0;
  logic [IDXW-1:0] unplugDoneSlot = '0;
  logic evtIrq, ejectValid, ostNotify;
  logic [IDXW-1:0] ejectSlot, ostSlot;
  logic [31:0] ostEvent, ostStatus;

  always #4 clk = ~clk;

  hotslot_regs #(.SLOTS(SLOTS)) u0 (.*);

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  // reference model
  bit mPres[SLOTS], mIns[SLOTS], mRem[SLOTS];
  logic [31:0] mEv[SLOTS];
  logic [31:0] mSel = 0;
  int mCmd = 0;

  // captured after each write
  logic cEj, cOst;
  logic [IDXW-1:0] cEjSlot, cOstSlot;
  logic [31:0] cOstEv, cOstSt;
  int cBusy;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit selOk();
    return mSel < SLOTS;
  endfunction

  function automatic logic [31:0] expFlags();
    if (!selOk()) return 0;
    return {29'd0, mRem[mSel[2:0]], mIns[mSel[2:0]], mPres[mSel[2:0]]};
  endfunction

  function automatic logic [31:0] expData();
    if (!selOk()) return 0;
    return (mCmd == 0) ? mSel : 0;
  endfunction

  function automatic bit expIrq();
    for (int i = 0; i < SLOTS; i++) if (mIns[i] || mRem[i]) return 1;
    return 0;
  endfunction

  task automatic busWrite(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    busReq = 1; busWr = 1; busAddr = a; busBe = be; busWdata = d;
    #1;
    while (!busReady) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    busReq = 0; busWr = 0;
    #1;
    cEj = ejectValid; cEjSlot = ejectSlot;
    cOst = ostNotify; cOstSlot = ostSlot; cOstEv = ostEvent; cOstSt = ostStatus;
    cBusy = 0;
    while (!busReady) begin cBusy++; @(negedge clk); #1; end
  endtask

  task automatic busRead(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    busReq = 1; busWr = 0; busAddr = a; busBe = 4'hF;
    #1;
    while (!busReady) begin @(negedge clk); #1; end
    v = busRdata;
    busReq = 0;
  endtask

  // model of a word-1 write; returns expected eject and scan length
  task automatic ctlWrite(input logic [3:0] be, input logic [31:0] d);
    bit ejExp; int busyExp; logic [31:0] newSel;
    ejExp = 0; busyExp = 0; newSel = mSel;
    if (selOk()) begin
      if (be[0]) begin
        if (d[1]) mIns[mSel[2:0]] = 0;
        else if (d[2]) mRem[mSel[2:0]] = 0;
        else if (d[3]) ejExp = mPres[mSel[2:0]] && mSel != 0;
      end
      if (be[1]) begin
        if (d[15:8] == 0) begin
          mCmd = 0;
          busyExp = SLOTS;
          for (int k = 0; k < SLOTS; k++) begin
            int idx;
            idx = (mSel + k) % SLOTS;
            if (mIns[idx] || mRem[idx]) begin newSel = idx; busyExp = k + 1; break; end
          end
        end else if (d[15:8] < 3) mCmd = d[15:8];
      end
    end
    busWrite(2'd1, be, d);
    check(cEj == ejExp, "R5 eject pulse", cEj, ejExp);
    if (ejExp) check(cEjSlot == mSel[2:0], "R5 eject slot", cEjSlot, mSel);
    check(cBusy == busyExp, "R7 scan length", cBusy, busyExp);
    mSel = newSel;
  endtask

  task automatic dataWrite(input logic [31:0] d);
    bit stExp;
    stExp = selOk() && mCmd == 2;
    busWrite(2'd2, 4'hF, d);
    check(cOst == stExp, "R9 notify pulse", cOst, stExp);
    if (stExp) begin
      check(cOstSlot == mSel[2:0], "R9 notify slot", cOstSlot, mSel);
      check(cOstEv == mEv[mSel[2:0]], "R9 notify event", cOstEv, mEv[mSel[2:0]]);
      check(cOstSt == d, "R9 notify status", cOstSt, d);
    end
    if (selOk() && mCmd == 1) mEv[mSel[2:0]] = d;
  endtask

  task automatic selWrite(input logic [3:0] be, input logic [31:0] d);
    for (int b = 0; b < 4; b++) if (be[b]) mSel[b*8 +: 8] = d[b*8 +: 8];
    busWrite(2'd0, be, d);
  endtask

  task automatic platEvent(input int kind, input int slot, input bit hot);
    @(negedge clk);
    case (kind)
      0: begin plugValid = 1; plugHot = hot; plugSlot = slot[2:0];
               mPres[slot] = 1; if (hot) mIns[slot] = 1; end
      1: begin unplugReqValid = 1; unplugReqSlot = slot[2:0]; mRem[slot] = 1; end
      default: begin unplugDoneValid = 1; unplugDoneSlot = slot[2:0]; mPres[slot] = 0; end
    endcase
    @(negedge clk);
    plugValid = 0; unplugReqValid = 0; unplugDoneValid = 0;
    #1;
    check(evtIrq == expIrq(), "R11 irq level", evtIrq, expIrq());
  endtask

  task automatic checkFlags(input string req);
    logic [31:0] v;
    busRead(2'd1, v);
    check(v == expFlags(), req, v, expFlags());
  endtask

  task automatic checkData(input string req);
    logic [31:0] v;
    busRead(2'd2, v);
    check(v == expData(), req, v, expData());
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2718));
    for (int i = 0; i < SLOTS; i++) begin mPres[i] = 0; mIns[i] = 0; mRem[i] = 0; mEv[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    check(evtIrq == 0, "R1 irq after reset", evtIrq, 0);
    check(busReady == 1, "R1 ready after reset", busReady, 1);
    checkFlags("R1 flags after reset");
    checkData("R1 selector/command after reset");
    busRead(2'd0, v); check(v == 0, "R2 word0 reads zero", v, 0);
    busRead(2'd3, v); check(v == 0, "R2 word3 reads zero", v, 0);

    // R10 plug: cold plug slot 0, hot plug slot 3
    platEvent(0, 0, 0);
    check(evtIrq == 0, "R10 cold plug no irq", evtIrq, 0);
    platEvent(0, 3, 1);
    selWrite(4'hF, 3);
    checkFlags("R2 R10 hot plug flags");
    // R8 data read under command 0 returns selector
    checkData("R8 data returns selector");

    // R7 wrap search from 5 to 3
    selWrite(4'hF, 5);
    ctlWrite(4'b0010, 32'h0000_0000);
    checkData("R7 wrap found slot 3");
    // R7 hit at start: one busy cycle
    ctlWrite(4'b0010, 32'h0000_0000);
    // R4 priority: bits 1,2,3 set -> only insert cleared
    platEvent(1, 3, 0);
    ctlWrite(4'b0001, 32'h0000_000E);
    checkFlags("R4 insert cleared first");
    ctlWrite(4'b0001, 32'h0000_000C);
    checkFlags("R4 remove cleared next");
    // R7 no events: selector unchanged, SLOTS cycles
    selWrite(4'hF, 6);
    ctlWrite(4'b0010, 32'h0000_0000);
    checkData("R7 no event keeps selector");

    // R5 eject cases
    selWrite(4'hF, 0); ctlWrite(4'b0001, 32'h8);   // boot slot
    selWrite(4'hF, 5); ctlWrite(4'b0001, 32'h8);   // absent
    selWrite(4'hF, 3); ctlWrite(4'b0001, 32'h8);   // present

    // R6 invalid command keeps command 0
    ctlWrite(4'b0010, 32'h0000_0500);
    checkData("R6 invalid command ignored");
    // R9 OST event then status
    ctlWrite(4'b0010, 32'h0000_0100);
    checkData("R8 data zero under command 1");
    dataWrite(32'hCAFE_0001);
    ctlWrite(4'b0010, 32'h0000_0200);
    dataWrite(32'h0000_0080);

    // R3 invalid selector: reads zero, writes ignored
    platEvent(1, 2, 0);
    selWrite(4'hF, 32'h0000_0040);
    checkFlags("R3 flags zero when selector out of range");
    checkData("R3 data zero when selector out of range");
    ctlWrite(4'b0011, 32'h0000_0004);
    dataWrite(32'h1234_5678);
    selWrite(4'hF, 2);
    checkFlags("R3 ignored write kept remove pending");

    // R12 selector byte merge
    selWrite(4'b0010, 32'h0000_0100);
    checkFlags("R12 merged selector out of range");
    selWrite(4'b0010, 32'h0000_0000);
    checkData("R12 merged selector back to 2");

    // R10 unplug completion clears present
    platEvent(2, 3, 0);
    selWrite(4'hF, 3);
    checkFlags("R10 unplug done clears present");

    // random phase
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom % 9;
      case (op)
        0: platEvent(0, $urandom % SLOTS, $urandom % 2);
        1: platEvent(1, $urandom % SLOTS, 0);
        2: platEvent(2, $urandom % SLOTS, 0);
        3: selWrite(4'hF, ($urandom % 8 == 0) ? SLOTS + ($urandom % 64) : $urandom % SLOTS);
        4: checkFlags("R2 random flags read");
        5: ctlWrite(4'b0001, $urandom % 16);
        6: begin
             int c;
             c = ($urandom % 5 == 0) ? 3 + ($urandom % 200) : $urandom % 3;
             ctlWrite(($urandom % 4 == 0) ? 4'b0011 : 4'b0010, (c << 8) | ($urandom % 16));
           end
        7: checkData("R8 random data read");
        default: dataWrite($urandom);
      endcase
    end
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule